// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block holds the word address of a synchronous burst memory and presents a registered access address every clock. When the command decoder asks for a new access, the block captures the external address. When it asks for the next beat, the block steps the two low address bits through a four-beat pattern and leaves the upper bits alone. When neither request is present, the address is held. This covers both suspended bursts and idle cycles.

A static order-select input chooses between two beat patterns. In counting order the low bits go up by one each beat, modulo four. In swap order beat n uses the starting low bits XOR n. In both patterns the fourth advance brings the low bits back to their starting value, with no carry into the upper address. Because a fresh load is accepted on any cycle, a user that never advances gets a plain registered address path with one cycle of latency.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and on the first clock after it ends, `acc_addr_o` is all zeros.
- R2: A cycle with `load_i` high makes `acc_addr_o` equal to `ext_addr_i` at the next clock edge.
- R3: If `load_i` and `step_i` are both high in one cycle, the load wins: the output becomes `ext_addr_i` and the beat count restarts at zero.
- R4: With `seq_lin_i` = 1 (counting order), the n-th advance after a load gives low bits equal to (start + n) mod 4.
- R5: With `seq_lin_i` = 0 (swap order), the n-th advance after a load gives low bits equal to start XOR (n mod 4).
- R6: A cycle with `load_i` and `step_i` both low leaves `acc_addr_o` unchanged.
- R7: An advance never changes `acc_addr_o[ADDR_W-1:2]`. This holds even when the low bits wrap from 3 to 0.
- R8: After four advances the low bits equal the loaded start value again, in both orders.
- R9: Loads on consecutive cycles each show up on the output, one cycle later, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Capture `ext_addr_i` and start a new burst |
| step_i | input | 1 | Advance to the next beat of the burst |
| seq_lin_i | input | 1 | Beat order: 1 = counting, 0 = swap (XOR) |
| ext_addr_i | input | ADDR_W | External word address |
| acc_addr_o | output | ADDR_W | Registered access address |

## Verification
A load and an advance can both be requested in the same cycle. The bench provokes this by asserting both in the middle of a burst, with the address held at a beat other than the start. It also provokes it right after a previous load. The result is judged correct only if the output takes the new external address, and if the next plain advance moves one beat away from the new start rather than continuing the old burst. The upper bits are set to all ones during bursts that wrap from 3 to 0, so any carry into them would show.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // What the sequencer does on a clock edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } seq_op_e;

  // A load takes priority over an advance.
  function automatic seq_op_e pick_op(input logic load, input logic step);
    if (load)      return OP_LOAD;
    else if (step) return OP_STEP;
    else           return OP_HOLD;
  endfunction

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_map.sv
module burst_beat_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              lin_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] swp_low;

  // Modulo-2^BEAT_W sum: the carry out is dropped on purpose.
  assign lin_low = start_i + beat_i;
  assign swp_low = start_i ^ beat_i;

  always_comb begin
    low_o = lin_i ? lin_low : swp_low;
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              seq_lin_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BEAT_W;

  seq_op_e           op;
  logic [UP_W-1:0]   upper_q,  upper_d;
  logic [BEAT_W-1:0] start_q,  start_d;
  logic [BEAT_W-1:0] beat_q,   beat_d;
  logic [BEAT_W-1:0] low_q,    low_d;
  logic [BEAT_W-1:0] beat_inc;
  logic [BEAT_W-1:0] map_low;
  logic              upd_en;

  assign op       = pick_op(load_i, step_i);
  assign beat_inc = beat_q + 1'b1;
  assign upd_en   = (op != OP_HOLD);

  burst_beat_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_inc),
    .lin_i   (seq_lin_i),
    .low_o   (map_low)
  );

  // Next-state logic
  always_comb begin
    upper_d = upper_q;
    start_d = start_q;
    beat_d  = beat_q;
    low_d   = low_q;
    unique case (op)
      OP_LOAD: begin
        upper_d = ext_addr_i[ADDR_W-1:BEAT_W];
        start_d = ext_addr_i[BEAT_W-1:0];
        beat_d  = '0;
        low_d   = ext_addr_i[BEAT_W-1:0];
      end
      OP_STEP: begin
        beat_d = beat_inc;
        low_d  = map_low;
      end
      default: ;
    endcase
  end

  // Register process with a clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      low_q   <= '0;
    end else if (upd_en) begin
      upper_q <= upper_d;
      start_q <= start_d;
      beat_q  <= beat_d;
      low_q   <= low_d;
    end
  end

  assign addr_o = {upper_q, low_q};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              seq_lin_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic rst_core_n;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  burst_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (load_i),
    .step_i     (step_i),
    .seq_lin_i  (seq_lin_i),
    .ext_addr_i (ext_addr_i),
    .addr_o     (acc_addr_o)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              load_i,
  input logic              step_i,
  input logic              seq_lin_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic [ADDR_W-1:0] acc_addr_o
);
  // Shadow model of the start value and the beat count, kept apart from the RTL.
  logic [BEAT_W-1:0] sh_start, sh_n, nxt_n, exp_lin, exp_swp;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sh_start <= '0;
      sh_n     <= '0;
    end else if (load_i) begin
      sh_start <= ext_addr_i[BEAT_W-1:0];
      sh_n     <= '0;
    end else if (step_i) begin
      sh_n     <= sh_n + 1'b1;
    end
  end

  assign nxt_n   = sh_n + 1'b1;
  assign exp_lin = sh_start + nxt_n;
  assign exp_swp = sh_start ^ nxt_n;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_i |=> acc_addr_o == $past(ext_addr_i));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_i && !step_i) |=> $stable(acc_addr_o));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_i && !load_i) |=> acc_addr_o[ADDR_W-1:BEAT_W] == $past(acc_addr_o[ADDR_W-1:BEAT_W]));

  p_lin_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_i && !load_i && seq_lin_i) |=> acc_addr_o[BEAT_W-1:0] == $past(exp_lin));

  p_swp_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step_i && !load_i && !seq_lin_i) |=> acc_addr_o[BEAT_W-1:0] == $past(exp_swp));

  // R1: the output stays zero while the core is held in reset.
  always_ff @(posedge clk) begin
    if (!rst_core_n) p_rst_zero_r1: assert (acc_addr_o == '0);
  end
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .load_i     (load_i),
  .step_i     (step_i),
  .seq_lin_i  (seq_lin_i),
  .ext_addr_i (ext_addr_i),
  .acc_addr_o (acc_addr_o)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i, step_i, seq_lin_i;
  logic [AW-1:0] ext_addr_i;
  logic [AW-1:0] acc_addr_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .seq_lin_i(seq_lin_i), .ext_addr_i(ext_addr_i), .acc_addr_o(acc_addr_o)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (acc_addr_o !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, acc_addr_o, exp);
    end
  endtask

  // Drive one cycle's inputs, clock, and settle away from the edge.
  task automatic cyc(input logic ld, input logic st, input logic [AW-1:0] a);
    load_i = ld; step_i = st; ext_addr_i = a;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load_i = 0; step_i = 0; seq_lin_i = 1; ext_addr_i = '1;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", '0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after reset", '0);
  endtask

  task automatic t_load;
    cyc(1, 0, 20'h12345); check("R2 load", 20'h12345);
  endtask

  task automatic t_linear;
    logic [1:0] e;
    seq_lin_i = 1;
    cyc(1, 0, 20'hABCD1); check("R2 load lin", 20'hABCD1);
    for (int n = 1; n <= 4; n++) begin
      cyc(0, 1, '0);
      e = 2'(1 + n);
      check(n == 4 ? "R8 lin wrap" : "R4 lin beat", {18'(20'hABCD1 >> 2), e});
    end
  endtask

  task automatic t_swap;
    logic [1:0] e;
    seq_lin_i = 0;
    cyc(1, 0, 20'h55551); check("R2 load swp", 20'h55551);
    for (int n = 1; n <= 4; n++) begin
      cyc(0, 1, '0);
      e = 2'(1 ^ (n % 4));
      check(n == 4 ? "R8 swp wrap" : "R5 swp beat", {18'(20'h55551 >> 2), e});
    end
  endtask

  task automatic t_hold;
    seq_lin_i = 1;
    cyc(1, 0, 20'h00F02);
    cyc(0, 1, '1);  check("R4 first beat", 20'h00F03);
    cyc(0, 0, '1);  check("R6 hold", 20'h00F03);
    cyc(0, 0, '0);  check("R6 hold again", 20'h00F03);
    cyc(0, 1, '0);  check("R4 after hold", 20'h00F00);
  endtask

  task automatic t_upper;
    seq_lin_i = 1;
    cyc(1, 0, 20'hFFFFF);
    cyc(0, 1, '0);  check("R7 no carry lin", 20'hFFFFC);
    seq_lin_i = 0;
    cyc(1, 0, 20'hFFFFF);
    cyc(0, 1, '0);  check("R7 upper swp", 20'hFFFFE);
  endtask

  task automatic t_priority;
    seq_lin_i = 1;
    cyc(1, 0, 20'h30000);
    cyc(0, 1, '0);  cyc(0, 1, '0); check("R4 beat2", 20'h30002);
    cyc(1, 1, 20'h40003); check("R3 load wins", 20'h40003);
    cyc(0, 1, '0);  check("R3 restart beat", 20'h40000);
    cyc(1, 1, 20'h7777D); check("R3 load wins again", 20'h7777D);
  endtask

  task automatic t_b2b;
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 20'(32'h1111 * (i + 1)));
      check("R9 back to back", 20'(32'h1111 * (i + 1)));
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_linear();
    t_swap();
    t_hold();
    t_upper();
    t_priority();
    t_b2b();
    cyc(0, 0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule